// File: doc/BRIEF.md
# Multiplexer and Gain Scan Sequencer

This block keeps a small scan list for an analog input front end. Each list entry names an input channel, a gain code and whether it is the final entry of the scan. Software loads the list one entry at a time. It first writes the entry index into a list pointer register, then writes the entry itself through an entry register. The pointer does not advance on its own during loading, so each entry needs its own pointer write.

During acquisition, an external conversion trigger makes the block present the entry at the pointer on its registered channel and gain outputs. The pointer then moves on. When the presented entry carries the final-entry marker, the pointer returns to entry 0 and an end-of-scan pulse is raised for one clock. The scan length is therefore set by where the marker sits in the list, not by a count.

With scanning disabled, the pointer stays where it is. Triggers then leave the outputs unchanged, and the outputs follow the entry most recently written. This is how single-channel acquisition is run. In differential input mode, the top channel bit is cleared on the output.

Top module: `mux_gain_sequencer`

## Requirements
- R1: After a synchronous active-low reset, chan_out and gain_out are 0, eos_pulse is low, the list pointer is 0 and every list entry is all zeros.
- R2: A write to register offset 0x04 loads the list pointer with wr_data[3:0]. The next scanning trigger then presents the entry at that index.
- R3: A write to offset 0x06 stores an entry at the pointer. Channel is wr_data[3:0], the final-entry marker is wr_data[4] and gain is wr_data[7:6]. The pointer does not advance, so repeated writes overwrite the same entry.
- R4: With scan_en high, a conv_trig cycle without a register write places the pointed entry's channel and gain on the outputs one clock later. The pointer then advances by one, modulo 16, when the entry carries no marker.
- R5: A scanning trigger on an entry whose marker is set returns the pointer to 0. It also drives eos_pulse high for exactly the following cycle. eos_pulse is never high at any other time.
- R6: With scan_en low, an entry write also updates chan_out and gain_out. A trigger changes neither the outputs nor the pointer and raises no eos_pulse.
- R7: With diff_mode high at the updating edge, bit 3 of chan_out is 0 whatever the stored channel.
- R8: chan_out and gain_out change only on a scanning trigger, or on an entry write while scanning is off. A pointer write or an idle cycle leaves them unchanged.
- R9: When a register write and conv_trig fall in the same cycle, the write takes effect and the trigger is ignored.
- R10: Writes to offsets other than 0x04 and 0x06 change neither the list, the pointer nor the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register byte offset |
| wr_data | input | 16 | Register write data |
| scan_en | input | 1 | Multi-entry scanning enable |
| diff_mode | input | 1 | Differential input mode, clears channel bit 3 |
| conv_trig | input | 1 | Conversion trigger, one cycle per conversion |
| chan_out | output | 4 | Registered channel select |
| gain_out | output | 2 | Registered gain code |
| eos_pulse | output | 1 | One-cycle end-of-scan pulse |

## Verification
The bench uses the default build: 16 entries, the pointer register at offset 0x04 and the entry register at 0x06. With this depth, a list with no marker can be run past entry 15 to show the pointer wrap. It also lets a marker at 0 give a one-entry scan that pulses on every trigger. The random phase mixes pointer writes, entry writes, stray offsets, same-cycle write-and-trigger and toggling of both mode inputs, so every event ordering meets every output state.

// File: rtl/mux_gain_seq_pkg.sv
// Shared widths and entry type for the scan sequencer.
// Assumes a 4-bit channel field and a 2-bit gain field per entry.
package mux_gain_seq_pkg;
    localparam int CHAN_W = 4;
    localparam int GAIN_W = 2;

    typedef struct packed {
        logic              last;
        logic [GAIN_W-1:0] gain;
        logic [CHAN_W-1:0] chan;
    } scan_entry_t;
endpackage

// File: rtl/scan_list_store.sv
// Scan list storage: one register per entry, written at an index and read
// asynchronously at another. Assumes a single write port.
module scan_list_store
    import mux_gain_seq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  scan_entry_t       wentry,
    input  logic [IDX_W-1:0]  ridx,
    output scan_entry_t       rentry
);
    scan_entry_t slots [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        // Hold one list entry; cleared on reset, replaced when its index is written.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slots[g] <= '0;
            else if (we && (widx == IDX_W'(g)))
                slots[g] <= wentry;
        end
    end

    // Present the entry at the read index.
    always_comb rentry = slots[ridx];
endmodule

// File: rtl/scan_pointer.sv
// List pointer shared by loading and sequencing. A load takes priority over
// an advance; an advance either steps by one (modulo depth) or wraps to 0.
module scan_pointer #(
    parameter int DEPTH = 16,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [IDX_W-1:0] load_val,
    input  logic             advance,
    input  logic             wrap,
    output logic [IDX_W-1:0] ptr
);
    logic [IDX_W-1:0] stepped;

    // Next index after the current one, wrapping at the list depth.
    always_comb begin
        if (ptr == IDX_W'(DEPTH - 1))
            stepped = '0;
        else
            stepped = ptr + 1'b1;
    end

    // Update the pointer on a load or a scanning advance.
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= load_val;
        else if (advance)
            ptr <= wrap ? '0 : stepped;
    end
endmodule

// File: rtl/scan_out_stage.sv
// Registered front-end outputs. Takes a new entry on a trigger step or a
// direct load, masks channel bit 3 in differential mode, and raises a
// one-cycle end-of-scan pulse on a step through a marked entry.
module scan_out_stage
    import mux_gain_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              step,
    input  scan_entry_t       step_entry,
    input  logic              direct,
    input  scan_entry_t       direct_entry,
    input  logic              diff_mode,
    output logic [CHAN_W-1:0] chan_out,
    output logic [GAIN_W-1:0] gain_out,
    output logic              eos_pulse
);
    scan_entry_t      pick;
    logic [CHAN_W-1:0] masked;

    // Choose the entry that updates the outputs this cycle.
    always_comb pick = direct ? direct_entry : step_entry;

    // Clear the top channel bit when the inputs are paired differentially.
    always_comb begin
        masked = pick.chan;
        if (diff_mode)
            masked[CHAN_W-1] = 1'b0;
    end

    // Hold channel and gain until the next update event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_out <= '0;
            gain_out <= '0;
        end else if (step || direct) begin
            chan_out <= masked;
            gain_out <= pick.gain;
        end
    end

    // Pulse end-of-scan for the cycle after a step through the final entry.
    always_ff @(posedge clk) begin
        if (!rst_n)
            eos_pulse <= 1'b0;
        else
            eos_pulse <= step && step_entry.last;
    end
endmodule

// File: rtl/mux_gain_sequencer.sv
// Multiplexer and gain scan sequencer top. Decodes the pointer and entry
// registers, stores the scan list and steps through it on conversion
// triggers. Assumes conv_trig is a one-cycle strobe per conversion.
module mux_gain_sequencer
    import mux_gain_seq_pkg::*;
#(
    parameter int DEPTH       = 16,
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int PTR_OFFSET  = 4,
    parameter int LIST_OFFSET = 6,
    parameter int MARK_BIT    = 4,
    parameter int GAIN_LSB    = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              scan_en,
    input  logic              diff_mode,
    input  logic              conv_trig,
    output logic [CHAN_W-1:0] chan_out,
    output logic [GAIN_W-1:0] gain_out,
    output logic              eos_pulse
);
    localparam int IDX_W = $clog2(DEPTH);

    logic             ptr_wr;
    logic             list_wr;
    logic             step;
    logic [IDX_W-1:0] ptr;
    scan_entry_t      new_entry;
    scan_entry_t      cur_entry;
    logic             unused_wr_bits;

    // Decode register writes and the scanning step; writes win over triggers.
    always_comb begin
        ptr_wr  = wr_en && (wr_addr == ADDR_W'(PTR_OFFSET));
        list_wr = wr_en && (wr_addr == ADDR_W'(LIST_OFFSET));
        step    = conv_trig && scan_en && !wr_en;
    end

    // Unpack the entry fields from the write data.
    always_comb begin
        new_entry.chan = wr_data[CHAN_W-1:0];
        new_entry.last = wr_data[MARK_BIT];
        new_entry.gain = wr_data[GAIN_LSB +: GAIN_W];
    end

    assign unused_wr_bits = ^wr_data;

    scan_list_store #(.DEPTH(DEPTH)) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (list_wr),
        .widx   (ptr),
        .wentry (new_entry),
        .ridx   (ptr),
        .rentry (cur_entry)
    );

    scan_pointer #(.DEPTH(DEPTH)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_wr),
        .load_val (wr_data[IDX_W-1:0]),
        .advance  (step),
        .wrap     (cur_entry.last),
        .ptr      (ptr)
    );

    scan_out_stage u_out (
        .clk          (clk),
        .rst_n        (rst_n),
        .step         (step),
        .step_entry   (cur_entry),
        .direct       (list_wr && !scan_en),
        .direct_entry (new_entry),
        .diff_mode    (diff_mode),
        .chan_out     (chan_out),
        .gain_out     (gain_out),
        .eos_pulse    (eos_pulse)
    );
endmodule

// File: rtl/mux_gain_sequencer_chk.sv
// Property checker for the scan sequencer, attached to the top by bind.
module mux_gain_sequencer_chk
    import mux_gain_seq_pkg::*;
#(
    parameter int ADDR_W      = 5,
    parameter int DATA_W      = 16,
    parameter int LIST_OFFSET = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              scan_en,
    input logic              diff_mode,
    input logic              conv_trig,
    input logic [CHAN_W-1:0] chan_out,
    input logic [GAIN_W-1:0] gain_out,
    input logic              eos_pulse
);
    logic entry_direct;
    assign entry_direct = wr_en && (wr_addr == ADDR_W'(LIST_OFFSET)) && !scan_en;

    a_r5_eos_follows_step: assert property (@(posedge clk) disable iff (!rst_n)
        eos_pulse |-> $past(conv_trig && scan_en && !wr_en));

    a_r8_hold_without_event: assert property (@(posedge clk) disable iff (!rst_n)
        (!(conv_trig && scan_en && !wr_en) && !entry_direct) |=>
            ($stable(chan_out) && $stable(gain_out)));

    a_r6_trigger_idle_off_scan: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_trig && !scan_en && !wr_en) |=>
            ($stable(chan_out) && $stable(gain_out) && !eos_pulse));

    a_r7_diff_clears_top_bit: assert property (@(posedge clk) disable iff (!rst_n)
        (diff_mode && ((conv_trig && scan_en && !wr_en) || entry_direct)) |=>
            !chan_out[CHAN_W-1]);

    a_r9_write_blocks_eos: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && conv_trig) |=> !eos_pulse);

    a_r6_direct_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        (entry_direct && !diff_mode) |=>
            (chan_out == $past(wr_data[CHAN_W-1:0])));
endmodule

bind mux_gain_sequencer mux_gain_sequencer_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LIST_OFFSET(LIST_OFFSET)
) u_chk (.*);

// File: tb/mux_gain_sequencer_tb.sv
`timescale 1ns/1ps
module mux_gain_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        scan_en = 1'b0;
    logic        diff_mode = 1'b0;
    logic        conv_trig = 1'b0;
    logic [3:0]  chan_out;
    logic [1:0]  gain_out;
    logic        eos_pulse;

    int checks = 0;
    int errors = 0;

    logic [6:0] m_list [16];
    logic [3:0] m_ptr;
    logic [3:0] m_chan;
    logic [1:0] m_gain;
    logic       m_eos;

    always #5 clk = ~clk;

    mux_gain_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .scan_en(scan_en), .diff_mode(diff_mode),
        .conv_trig(conv_trig), .chan_out(chan_out), .gain_out(gain_out),
        .eos_pulse(eos_pulse)
    );

    initial begin
        #2000000;
        errors++;
        $display("FAIL watchdog: run did not complete (actual hung, expected done)");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    function automatic logic [3:0] mask_chan(input logic [3:0] c, input logic d);
        return d ? {1'b0, c[2:0]} : c;
    endfunction

    // Expected next state from R2..R10, evaluated with this cycle's inputs.
    task automatic model_edge();
        logic [6:0] cur;
        logic [6:0] ent;
        cur = m_list[m_ptr];
        ent = {wr_data[4], wr_data[7:6], wr_data[3:0]};
        m_eos = 1'b0;
        if (wr_en && wr_addr == 5'd4) begin
            m_ptr = wr_data[3:0];
        end else if (wr_en && wr_addr == 5'd6) begin
            m_list[m_ptr] = ent;
            if (!scan_en) begin
                m_chan = mask_chan(ent[3:0], diff_mode);
                m_gain = ent[5:4];
            end
        end else if (!wr_en && conv_trig && scan_en) begin
            m_chan = mask_chan(cur[3:0], diff_mode);
            m_gain = cur[5:4];
            m_eos  = cur[6];
            m_ptr  = cur[6] ? 4'd0 : m_ptr + 4'd1;
        end
    endtask

    task automatic compare(input string tag);
        checks++;
        if (chan_out !== m_chan || gain_out !== m_gain || eos_pulse !== m_eos) begin
            errors++;
            $display("FAIL %s: actual chan=%0d gain=%0d eos=%0b expected chan=%0d gain=%0d eos=%0b",
                     tag, chan_out, gain_out, eos_pulse, m_chan, m_gain, m_eos);
        end
    endtask

    // Drive one cycle of inputs at the falling edge, then check after the rise.
    task automatic cycle(input logic we, input logic [4:0] a, input logic [15:0] d,
                         input logic tr, input string tag);
        wr_en = we; wr_addr = a; wr_data = d; conv_trig = tr;
        model_edge();
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; conv_trig = 1'b0;
        compare(tag);
    endtask

    task automatic set_ptr(input logic [3:0] p, input string tag);
        cycle(1'b1, 5'd4, {12'h0, p}, 1'b0, tag);
    endtask

    task automatic put_entry(input logic [3:0] c, input logic lst, input logic [1:0] g,
                             input string tag);
        cycle(1'b1, 5'd6, {8'h0, g, 1'b0, lst, c}, 1'b0, tag);
    endtask

    task automatic trig(input string tag);
        cycle(1'b0, 5'd0, 16'h0, 1'b1, tag);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) m_list[i] = '0;
        m_ptr = '0; m_chan = '0; m_gain = '0; m_eos = 1'b0;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        compare("R1 reset state");

        // R1: list is empty after reset, a scan trigger presents zeros.
        scan_en = 1'b1;
        trig("R1 empty list after reset");

        // R3 R4 R5: three-entry scan, marker on entry 2.
        set_ptr(4'd0, "R8 pointer write holds outputs");
        put_entry(4'd9, 1'b0, 2'd1, "R3 load entry 0");
        set_ptr(4'd1, "R2 pointer write");
        put_entry(4'd3, 1'b0, 2'd2, "R3 load entry 1");
        set_ptr(4'd2, "R2 pointer write");
        put_entry(4'd14, 1'b1, 2'd3, "R3 load entry 2 with marker");
        set_ptr(4'd0, "R2 rewind");
        for (int k = 0; k < 7; k++) trig("R4 R5 scan step");
        cycle(1'b0, 5'd0, 16'h0, 1'b0, "R5 eos one cycle only");

        // R3: no auto-increment, second write overwrites entry 0.
        set_ptr(4'd0, "R2 rewind");
        put_entry(4'd5, 1'b0, 2'd0, "R3 first write");
        put_entry(4'd6, 1'b0, 2'd2, "R3 overwrite same index");
        set_ptr(4'd0, "R2 rewind");
        trig("R3 entry 0 holds last write");

        // R2: jump into the middle of the list.
        set_ptr(4'd7, "R2 pointer to 7");
        put_entry(4'd11, 1'b1, 2'd1, "R3 entry 7");
        set_ptr(4'd7, "R2 pointer to 7");
        trig("R2 entry 7 presented");
        trig("R5 wrapped to entry 0");

        // R4: no marker anywhere, pointer wraps modulo 16.
        for (int i = 0; i < 16; i++) begin
            set_ptr(i[3:0], "R2 fill");
            put_entry(i[3:0], 1'b0, i[1:0], "R3 fill");
        end
        set_ptr(4'd0, "R2 rewind");
        for (int k = 0; k < 18; k++) trig("R4 modulo wrap");

        // R5: single marked entry scans every trigger.
        set_ptr(4'd0, "R2 rewind");
        put_entry(4'd2, 1'b1, 2'd3, "R3 single marker");
        set_ptr(4'd0, "R2 rewind");
        trig("R5 one-entry scan");
        trig("R5 one-entry scan repeat");

        // R6: scanning off, load drives outputs, triggers do nothing.
        scan_en = 1'b0;
        set_ptr(4'd3, "R8 pointer write scan off");
        put_entry(4'd12, 1'b0, 2'd2, "R6 direct load");
        trig("R6 trigger ignored");
        trig("R6 trigger ignored again");

        // R7: differential mode clears channel bit 3.
        diff_mode = 1'b1;
        put_entry(4'd15, 1'b0, 2'd1, "R7 direct load masked");
        scan_en = 1'b1;
        set_ptr(4'd8, "R2 pointer to 8");
        put_entry(4'd13, 1'b1, 2'd0, "R3 entry 8");
        set_ptr(4'd8, "R2 pointer to 8");
        trig("R7 scanned channel masked");
        diff_mode = 1'b0;

        // R9: write and trigger together, write wins.
        set_ptr(4'd8, "R2 pointer to 8");
        cycle(1'b1, 5'd4, 16'h0001, 1'b1, "R9 pointer write beats trigger");
        trig("R9 trigger after combined cycle");

        // R10: writes to other offsets have no effect.
        cycle(1'b1, 5'd8, 16'hFFFF, 1'b0, "R10 stray offset 0x08");
        cycle(1'b1, 5'd5, 16'h00DF, 1'b1, "R10 stray offset with trigger");
        set_ptr(4'd8, "R2 pointer to 8");
        trig("R10 list unchanged");

        // Random mix over all inputs.
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [4:0] a;
            op = int'($urandom_range(0, 9));
            scan_en   = ($urandom_range(0, 4) != 0);
            diff_mode = ($urandom_range(0, 3) == 0);
            case (op)
                0, 1:    a = 5'd4;
                2, 3:    a = 5'd6;
                4:       a = 5'($urandom_range(0, 31));
                default: a = 5'd0;
            endcase
            if (op <= 4)
                cycle(1'b1, a, 16'($urandom), ($urandom_range(0, 1) == 1), "R8 random mix");
            else
                cycle(1'b0, 5'd0, 16'h0, (op != 9), "R4 random trigger");
        end

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule